// File: doc/BRIEF.md
# Lookahead LFSR Uniform Sample Unit

This unit is a pipeline functional unit that produces one uniformly distributed 32-bit pseudo-random sample per accepted request. Its state is a 39-bit shift register with XOR feedback for the primitive polynomial x^39 + x^35 + 1. Each sample request moves the register forward by 32 single-bit steps at once, so a new sample is ready every cycle and the unit never holds up the pipeline.

The raw sample is read as a signed two's-complement number and shifted arithmetically right by (31 − scale), where scale is a 5-bit operand. The returned word is a uniform fixed-point value in [−1, 1) with `scale` fractional bits. A seed operation writes the register state from an operand. A zero seed is replaced by a fixed nonzero constant, so the register can never lock up. A single request can carry both a seed and a sample. In that case the sample is drawn from the freshly written seed.

Top module: `urng_unit`

## Requirements
- R1: During and after a synchronous active-low reset, `res_valid` is 0, `res_data` is 0 and the register state is 39'h1. The first sample after reset is drawn from that state.
- R2: The feedback bit of a single step of state s is s[38] ^ s[34], and the state becomes {s[37:0], fb}. A sample's raw word has the feedback bit of step k (k = 0..31) at bit 31−k.
- R3: `req_ready` is always 1. A sample request accepted at a clock edge produces `res_valid` = 1 and its `res_data` right after that edge. Back-to-back requests give one result per cycle.
- R4: Each sample request advances the state by exactly 32 single-bit steps, so consecutive samples continue one unbroken bit stream.
- R5: `res_data` equals the raw word interpreted as signed and shifted arithmetically right by (31 − `req_scale`). Scale 31 returns the raw word, and scale 0 returns only the sign (0 or −1).
- R6: `req_op` bit 0 requests a sample and bit 1 requests a seed load (2'b00 idle, 2'b01 sample, 2'b10 seed, 2'b11 seed then sample). A seed-only request loads `req_seed` into the state at the next edge. It gives `res_valid` = 0 and leaves `res_data` unchanged.
- R7: A seed of zero loads the constant 39'h1 instead, so the state is never zero.
- R8: With `req_op` = 2'b11, the sample is drawn from the new seed (after the zero replacement). The state after the edge is that seed advanced by 32 steps.
- R9: A cycle without an accepted request, or with op 2'b00, leaves the state unchanged and gives `res_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Always 1: requests are accepted every cycle |
| req_op | input | 2 | Bit 0 = sample, bit 1 = seed load |
| req_seed | input | 39 | Seed operand |
| req_scale | input | 5 | Number of fractional bits of the result |
| res_valid | output | 1 | Result present for the request of the previous cycle |
| res_data | output | 32 | Scaled signed sample |

## Verification
A seed load and a sample request can fall in the same cycle. The bench provokes this with op 2'b11 requests, using a zero seed and several nonzero seeds, placed between plain sample runs. The result is judged against a bit-serial model that first replaces the state with the seed and then steps 32 times. The sample after that is also compared, which shows that the advanced seed, not the old state, was kept. Seed-only requests are judged at the ports: the result flag stays low, the data word holds, and the next sample reflects the loaded state.

// File: rtl/urng_pkg.sv
// Package: shared opcode encoding for the uniform sample unit.
// Assumes a 2-bit opcode whose bit 0 requests a sample and bit 1 a seed load.
package urng_pkg;

    typedef enum logic [1:0] {
        OP_IDLE        = 2'b00,
        OP_SAMPLE      = 2'b01,
        OP_SEED        = 2'b10,
        OP_SEED_SAMPLE = 2'b11
    } urng_op_e;

    localparam int OP_BIT_SAMPLE = 0;
    localparam int OP_BIT_SEED   = 1;

endpackage

// File: rtl/urng_lookahead.sv
// Module: urng_lookahead
// Combinational unrolling of a Fibonacci LFSR over STEPS single-bit steps.
// Each step computes fb = s[W-1] ^ s[TAP-1] and shifts it in at bit 0.
// The feedback bit of step k is placed at bit (STEPS-1-k) of bits_o.
// Assumes TAP < W and STEPS >= 1.
module urng_lookahead #(
    parameter int STATE_W = 39,
    parameter int TAP     = 35,
    parameter int STEPS   = 32
) (
    input  logic [STATE_W-1:0] state_i,
    output logic [STATE_W-1:0] state_o,
    output logic [STEPS-1:0]   bits_o
);

    localparam int HI = STATE_W - 1;
    localparam int LO = TAP - 1;

    // Walk the register STEPS times and collect every feedback bit.
    always_comb begin
        logic [STATE_W-1:0] walk;
        logic               fb;
        walk   = state_i;
        bits_o = '0;
        for (int k = 0; k < STEPS; k++) begin
            fb                 = walk[HI] ^ walk[LO];
            bits_o[STEPS-1-k]  = fb;
            walk               = {walk[HI-1:0], fb};
        end
        state_o = walk;
    end

endmodule

// File: rtl/urng_scaler.sv
// Module: urng_scaler
// Logarithmic barrel shifter: arithmetic right shift of a signed sample by
// (DATA_W-1 - scale_i). One stage per shift-amount bit, built by generate.
// Assumes DATA_W is a power of two, so that SH_W bits hold DATA_W-1 exactly.
module urng_scaler #(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] raw_i,
    input  logic [SH_W-1:0]   scale_i,
    output logic [DATA_W-1:0] data_o
);

    localparam logic [SH_W-1:0] MAX_SH = SH_W'(DATA_W - 1);

    logic [SH_W-1:0]   shamt;
    logic [DATA_W-1:0] stage [0:SH_W];

    // Convert the fractional-bit count into a right-shift distance.
    always_comb shamt = MAX_SH - scale_i;

    assign stage[0] = raw_i;

    genvar g;
    generate
        for (g = 0; g < SH_W; g++) begin : g_stage
            localparam int DIST = 1 << g;
            logic [DATA_W-1:0] shifted;
            // Sign-filling shift by a fixed power of two.
            always_comb shifted = {{DIST{stage[g][DATA_W-1]}}, stage[g][DATA_W-1:DIST]};
            // Select the shifted or the passed-through word for this stage.
            assign stage[g+1] = shamt[g] ? shifted : stage[g];
        end
    endgenerate

    assign data_o = stage[SH_W];

endmodule

// File: rtl/urng_state.sv
// Module: urng_state
// Holds the LFSR state and chooses the state fed to the lookahead network.
// A seed load replaces the working state. A zero seed is swapped for
// FALLBACK, so the register never becomes zero.
// A sample stores the advanced state. Otherwise the register holds.
// Assumes FALLBACK is nonzero. Synchronous active-low reset to FALLBACK.
module urng_state #(
    parameter int                  STATE_W  = 39,
    parameter logic [STATE_W-1:0]  FALLBACK = 39'h1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_en,
    input  logic               sample_en,
    input  logic [STATE_W-1:0] seed_i,
    input  logic [STATE_W-1:0] advanced_i,
    output logic [STATE_W-1:0] work_o,
    output logic [STATE_W-1:0] state_q
);

    logic [STATE_W-1:0] seed_clean;
    logic [STATE_W-1:0] state_d;

    // Replace an all-zero seed by the nonzero fallback constant.
    always_comb seed_clean = (seed_i == '0) ? FALLBACK : seed_i;

    // State the lookahead network works from this cycle.
    always_comb work_o = load_en ? seed_clean : state_q;

    // Next-state choice: advanced, freshly seeded, or held.
    always_comb begin
        if (sample_en)    state_d = advanced_i;
        else if (load_en) state_d = seed_clean;
        else              state_d = state_q;
    end

    // State register with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FALLBACK;
        else        state_q <= state_d;
    end

endmodule

// File: rtl/urng_unit.sv
// Module: urng_unit (top)
// Uniform sample unit: 39-bit LFSR advanced 32 steps per sample request,
// followed by a fixed-point scale shifter and a result register.
// Accepts a request every cycle. The result appears the cycle after acceptance.
// Assumes SAMPLE_W is a power of two and SAMPLE_W <= STATE_W.
module urng_unit
    import urng_pkg::*;
#(
    parameter int                 STATE_W  = 39,
    parameter int                 TAP      = 35,
    parameter int                 SAMPLE_W = 32,
    parameter logic [STATE_W-1:0] FALLBACK = 39'h1,
    localparam int                SCALE_W  = $clog2(SAMPLE_W)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_op,
    input  logic [STATE_W-1:0]  req_seed,
    input  logic [SCALE_W-1:0]  req_scale,
    output logic                res_valid,
    output logic [SAMPLE_W-1:0] res_data
);

    logic               do_sample;
    logic               do_load;
    logic [STATE_W-1:0] work_state;
    logic [STATE_W-1:0] adv_state;
    logic [STATE_W-1:0] state_q;
    logic [SAMPLE_W-1:0] raw_bits;
    logic [SAMPLE_W-1:0] scaled;

    // The unit never stalls, so it is always ready.
    assign req_ready = 1'b1;

    // Decode the opcode bits of an accepted request.
    always_comb begin
        do_sample = req_valid & req_op[OP_BIT_SAMPLE];
        do_load   = req_valid & req_op[OP_BIT_SEED];
    end

    urng_state #(
        .STATE_W  (STATE_W),
        .FALLBACK (FALLBACK)
    ) u_state (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_en    (do_load),
        .sample_en  (do_sample),
        .seed_i     (req_seed),
        .advanced_i (adv_state),
        .work_o     (work_state),
        .state_q    (state_q)
    );

    urng_lookahead #(
        .STATE_W (STATE_W),
        .TAP     (TAP),
        .STEPS   (SAMPLE_W)
    ) u_look (
        .state_i (work_state),
        .state_o (adv_state),
        .bits_o  (raw_bits)
    );

    urng_scaler #(
        .DATA_W (SAMPLE_W)
    ) u_scale (
        .raw_i   (raw_bits),
        .scale_i (req_scale),
        .data_o  (scaled)
    );

    // Result register: capture scaled sample, hold data when no sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
        end else begin
            res_valid <= do_sample;
            if (do_sample) res_data <= scaled;
        end
    end

endmodule

// File: rtl/urng_checker.sv
// Module: urng_checker
// Temporal properties of urng_unit, attached by bind below.
// Uses an armed flag so that no $past reaches into the reset period.
module urng_checker #(
    parameter int STATE_W  = 39,
    parameter int SAMPLE_W = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                req_valid,
    input logic                req_ready,
    input logic [1:0]          req_op,
    input logic [STATE_W-1:0]  req_seed,
    input logic                res_valid,
    input logic [SAMPLE_W-1:0] res_data,
    input logic [STATE_W-1:0]  state_q
);

    logic armed;

    // Becomes 1 one cycle after reset is released.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    assert_always_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready);

    assert_result_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> (res_valid == ($past(req_valid) && $past(req_op[0]))));

    assert_seed_loaded_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $past(req_valid) && $past(req_op) == 2'b10 && $past(req_seed) != '0)
        |-> (state_q == $past(req_seed)));

    assert_data_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !res_valid) |-> $stable(res_data));

    assert_state_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && (!$past(req_valid) || $past(req_op) == 2'b00)) |-> $stable(state_q));

endmodule

bind urng_unit urng_checker #(
    .STATE_W  (STATE_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_op    (req_op),
    .req_seed  (req_seed),
    .res_valid (res_valid),
    .res_data  (res_data),
    .state_q   (state_q)
);

// File: tb/sim_urng_unit.sv
// Bench for urng_unit: bit-serial reference model, sweeps over all scales,
// seeds, long back-to-back runs, and combined seed+sample requests.
module sim_urng_unit;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = 2'b00;
    logic [38:0] req_seed = '0;
    logic [4:0]  req_scale = '0;
    logic        res_valid;
    logic [31:0] res_data;

    int checks   = 0;
    int failures = 0;

    logic [38:0] m_state;
    logic [31:0] exp_data;
    logic        exp_valid;

    always #(CLK_PERIOD/2) clk = ~clk;

    urng_unit u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_seed  (req_seed),
        .req_scale (req_scale),
        .res_valid (res_valid),
        .res_data  (res_data)
    );

    // Bit-serial reference: 32 single steps, feedback bits collected MSB first.
    function automatic logic [31:0] ref_advance(inout logic [38:0] s);
        logic [31:0] bits;
        logic        fb;
        for (int k = 0; k < 32; k++) begin
            fb = s[38] ^ s[34];
            bits = {bits[30:0], fb};
            s = {s[37:0], fb};
        end
        return bits;
    endfunction

    // Floor division by 2^(31-scale) of the signed raw word.
    function automatic logic [31:0] ref_scale(logic [31:0] raw, int scale);
        longint v, d, q;
        v = longint'($signed(raw));
        d = longint'(1) << (31 - scale);
        q = v / d;
        if ((v % d) != 0 && v < 0) q = q - 1;
        return q[31:0];
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    // Drive one request at a negedge, then check outputs at the next negedge.
    task automatic send(logic [1:0] op, logic [38:0] seed, int scale, string req);
        req_valid = (op != 2'b00);
        req_op    = op;
        req_seed  = seed;
        req_scale = scale[4:0];
        if (op[1]) m_state = (seed == '0) ? 39'h1 : seed;
        if (op[0]) begin
            exp_data  = ref_scale(ref_advance(m_state), scale);
            exp_valid = 1'b1;
        end else begin
            exp_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        check({req, " valid"}, 64'(res_valid), 64'(exp_valid));
        check({req, " data"}, 64'(res_data), 64'(exp_data));
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [38:0] seeds [0:5];
        seeds[0] = 39'h7F_FFFF_FFFF;
        seeds[1] = 39'h40_0000_0000;
        seeds[2] = 39'h00_0000_0001;
        seeds[3] = 39'h12_3456_789A;
        seeds[4] = 39'h55_5555_5555;
        seeds[5] = 39'h00_8000_0400;

        m_state   = 39'h1;
        exp_data  = '0;
        exp_valid = 1'b0;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 reset valid", 64'(res_valid), 64'd0);
        check("R1 reset data", 64'(res_data), 64'd0);
        check("R3 ready", 64'(req_ready), 64'd1);
        rst_n = 1'b1;

        // R1 R2 R5: first samples after reset from the reset state, raw scale
        send(2'b01, '0, 31, "R1 first sample");
        send(2'b01, '0, 31, "R2 raw sample");

        // R9: idle cycles leave state untouched, next sample continues stream
        send(2'b00, 39'h3, 31, "R9 idle");
        req_valid = 1'b0;
        req_op    = 2'b01;
        @(posedge clk);
        @(negedge clk);
        check("R9 invalid request valid", 64'(res_valid), 64'd0);
        send(2'b01, '0, 31, "R9 after idle");

        // R5: every scale for every seed, back-to-back (R3 R4)
        foreach (seeds[i]) begin
            send(2'b10, seeds[i], 0, "R6 seed only");
            for (int sc = 0; sc < 32; sc++)
                send(2'b01, '0, sc, "R5 scale sweep");
        end

        // R4: long unbroken stream at full width and at mid scale
        for (int n = 0; n < 3000; n++)
            send(2'b01, '0, (n % 3 == 0) ? 15 : 31, "R4 stream");

        // R7: zero seed replaced by constant
        send(2'b10, '0, 31, "R7 zero seed");
        send(2'b01, '0, 31, "R7 sample after zero seed");

        // R8: seed and sample in same cycle, then continuation
        foreach (seeds[i]) begin
            send(2'b01, '0, 31, "R8 prior sample");
            send(2'b11, seeds[i], 31, "R8 seed+sample");
            send(2'b01, '0, 20, "R8 follow-up");
        end
        send(2'b11, '0, 31, "R8 R7 zero seed+sample");
        send(2'b01, '0, 31, "R8 follow-up zero");

        // R6: seed-only keeps data; back-to-back seeds, last one wins
        send(2'b10, 39'h1_0000_0000, 31, "R6 seed a");
        send(2'b10, 39'h2A_0F0F_0F0F, 31, "R6 seed b");
        send(2'b01, '0, 31, "R6 sample from last seed");

        send(2'b00, '0, 0, "R9 final idle");
        finish_run();
    end

endmodule